// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs the external bus machine cycle of a small processor whose low address byte and data byte share one set of bidirectional pins. A request carries a 16-bit address, a cycle kind (read, write or bus-idle), a memory/I-O select and write data. The sequencer then steps through three bus states, called T1, T2 and T3 here. T1 presents the address and pulses an address-latch strobe so that an external latch can hold the low byte. T2 and T3 move the data byte over the same pins, under an active-low read or write strobe.

A bus-idle cycle takes the same three states but drives nothing onto the bus. It is still reported complete. A new request is accepted while the sequencer sits idle or is in T3, so cycles can run back to back without a dead cycle. Read data is captured from the shared pins at the edge that ends T3. A one-cycle done pulse goes out with it.

Top module: `mux_bus_seq`

## Requirements
- R1: While reset is held and right after it, the outputs are at rest: `ale`=0, `rd_n`=1, `wr_n`=1, `ad_oe`=0, `addr_hi_oe`=0, status {`stat_io`,`stat_s1`,`stat_s0`}=000, `rsp_done`=0 and `req_ready`=1. Reset is asynchronous and active low.
- R2: For a read or write cycle, `ale` is 1 in exactly the one cycle of T1. T1 is the cycle after the request is accepted.
- R3: In T1 of a read or write cycle, `ad_oe`=1 and `ad_out` carries address bits [7:0].
- R4: Throughout T1, T2 and T3 of a read or write cycle, `addr_hi_oe`=1 and `addr_hi` carries address bits [15:8].
- R5: The status {`stat_io`,`stat_s1`,`stat_s0`} is held from T1 through T3. The codes are: memory read 010, memory write 001, I/O read 110, I/O write 101. The value is 000 when no cycle runs and during a bus-idle cycle.
- R6: `rd_n` is 0 only in T2 and T3 of a read cycle. `wr_n` is 0 only in T2 and T3 of a write cycle. The two are never 0 together.
- R7: In a write cycle, `ad_oe`=1 and `ad_out` equals the write data from the start of T2 through the end of T3.
- R8: In a read cycle, `ad_oe`=0 in T2 and T3, which releases the shared pins to the device.
- R9: In a read cycle, `ad_in` is sampled at the clock edge that ends T3. In the cycle after that edge, `rsp_rdata` shows the sampled value and `rsp_done`=1 for one cycle. Write and bus-idle cycles also pulse `rsp_done` but leave `rsp_rdata` unchanged.
- R10: A bus-idle cycle (`req_kind` 00, or the spare code 11) runs T1 to T3 with `ale`=0, `ad_oe`=0, `addr_hi_oe`=0, both strobes high and status 000.
- R11: `req_ready` is 1 only when idle or in T3. A request made while `req_ready`=0 is ignored. A request accepted in T3 starts its T1 in the very next cycle. Codes for `req_kind`: 01 read, 10 write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | Cycle kind: 00 bus-idle, 01 read, 10 write, 11 bus-idle |
| req_io | input | 1 | 1 selects the I/O space, 0 selects memory |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Request accepted on this edge if valid |
| rsp_rdata | output | 8 | Last captured read data |
| rsp_done | output | 1 | One-cycle pulse after a cycle ends |
| ale | output | 1 | Address latch strobe, active high |
| ad_out | output | 8 | Shared pins, driven value |
| ad_oe | output | 1 | Shared pins output enable |
| ad_in | input | 8 | Shared pins, sensed value |
| addr_hi | output | 8 | High address byte |
| addr_hi_oe | output | 1 | High address output enable |
| stat_io | output | 1 | Status: I/O space select |
| stat_s1 | output | 1 | Status bit 1 (read) |
| stat_s0 | output | 1 | Status bit 0 (write) |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
A wrong state register shows at the ports within one cycle. The `ale` pulse or a strobe would appear in the wrong cycle, or last for other than one or two cycles. A latched cycle kind or address that is wrong shows up as a bad status code or bad address bytes in T1, before any strobe fires. A fault in the capture path only shows in the cycle after T3, as a wrong `rsp_rdata` or a missing `rsp_done`. The bench therefore checks every bus state of every cycle, including the overlap of a done pulse with the T1 of the next back-to-back cycle.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef enum logic [1:0] {
    TS_IDLE = 2'd0,
    TS_T1   = 2'd1,
    TS_T2   = 2'd2,
    TS_T3   = 2'd3
  } tstate_e;

  typedef enum logic [1:0] {
    K_NONE  = 2'b00,
    K_READ  = 2'b01,
    K_WRITE = 2'b10,
    K_SPARE = 2'b11
  } kind_e;

  // {io, s1, s0}; non-transfer kinds report 000
  function automatic logic [2:0] status_code(input logic io, input kind_e k);
    case (k)
      K_READ:  status_code = {io, 2'b10};
      K_WRITE: status_code = {io, 2'b01};
      default: status_code = 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/mbs_rst_sync.sv
module mbs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/mbs_ctrl.sv
module mbs_ctrl
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic              req_io,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output tstate_e           state,
  output kind_e             kind,
  output logic              io_sel,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata
);
  tstate_e state_q, state_d;
  kind_e   kind_q;
  logic    io_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic accept;

  assign req_ready = (state_q == TS_IDLE) || (state_q == TS_T3);
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_d = state_q;
    case (state_q)
      TS_IDLE: if (accept) state_d = TS_T1;
      TS_T1:   state_d = TS_T2;
      TS_T2:   state_d = TS_T3;
      TS_T3:   state_d = accept ? TS_T1 : TS_IDLE;
      default: state_d = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= TS_IDLE;
    else        state_q <= state_d;
  end

  // request latch, loaded only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= K_NONE;
      io_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      kind_q  <= kind_e'(req_kind);
      io_q    <= req_io;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  assign state  = state_q;
  assign kind   = kind_q;
  assign io_sel = io_q;
  assign addr   = addr_q;
  assign wdata  = wdata_q;
endmodule

// File: rtl/mbs_drive.sv
module mbs_drive
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W = ADDR_W - DATA_W
) (
  input  tstate_e           state,
  input  kind_e             kind,
  input  logic              io_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ale,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [HI_W-1:0]   addr_hi,
  output logic              addr_hi_oe,
  output logic [2:0]        status,
  output logic              rd_n,
  output logic              wr_n
);
  logic is_rd, is_wr, live, in_cycle;

  assign is_rd    = (kind == K_READ);
  assign is_wr    = (kind == K_WRITE);
  assign live     = is_rd || is_wr;
  assign in_cycle = (state != TS_IDLE);

  always_comb begin
    ale        = 1'b0;
    ad_out     = '0;
    ad_oe      = 1'b0;
    addr_hi    = '0;
    addr_hi_oe = 1'b0;
    status     = 3'b000;
    rd_n       = 1'b1;
    wr_n       = 1'b1;
    if (in_cycle) begin
      status = status_code(io_sel, kind);
      if (live) begin
        addr_hi    = addr[ADDR_W-1:DATA_W];
        addr_hi_oe = 1'b1;
      end
    end
    case (state)
      TS_T1: if (live) begin
        ale    = 1'b1;
        ad_oe  = 1'b1;
        ad_out = addr[DATA_W-1:0];
      end
      TS_T2, TS_T3: begin
        rd_n = !is_rd;
        wr_n = !is_wr;
        if (is_wr) begin
          ad_oe  = 1'b1;
          ad_out = wdata;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mbs_capture.sv
module mbs_capture
  import mbs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tstate_e           state,
  input  kind_e             kind,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);
  logic              last_t;
  logic              cap_en;
  logic [DATA_W-1:0] rdata_q;
  logic              done_q;

  assign last_t = (state == TS_T3);
  assign cap_en = last_t && (kind == K_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_en) rdata_q <= ad_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= last_t;
  end

  assign rdata = rdata_q;
  assign done  = done_q;
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic              req_io,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done,
  output logic              ale,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in,
  output logic [HI_W-1:0]   addr_hi,
  output logic              addr_hi_oe,
  output logic              stat_io,
  output logic              stat_s1,
  output logic              stat_s0,
  output logic              rd_n,
  output logic              wr_n
);
  logic              rst_sync_n;
  tstate_e           state;
  kind_e             kind;
  logic              io_sel;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;
  logic [2:0]        status;

  mbs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mbs_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_io    (req_io),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_ready (req_ready),
    .state     (state),
    .kind      (kind),
    .io_sel    (io_sel),
    .addr      (addr),
    .wdata     (wdata)
  );

  mbs_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
    .state      (state),
    .kind       (kind),
    .io_sel     (io_sel),
    .addr       (addr),
    .wdata      (wdata),
    .ale        (ale),
    .ad_out     (ad_out),
    .ad_oe      (ad_oe),
    .addr_hi    (addr_hi),
    .addr_hi_oe (addr_hi_oe),
    .status     (status),
    .rd_n       (rd_n),
    .wr_n       (wr_n)
  );

  mbs_capture #(.DATA_W(DATA_W)) u_cap (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .state (state),
    .kind  (kind),
    .ad_in (ad_in),
    .rdata (rsp_rdata),
    .done  (rsp_done)
  );

  assign {stat_io, stat_s1, stat_s0} = status;
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_done,
  input logic ale,
  input logic ad_oe,
  input logic addr_hi_oe,
  input logic stat_io,
  input logic stat_s1,
  input logic stat_s0,
  input logic rd_n,
  input logic wr_n
);
  // R6: strobes are exclusive
  a_r6_no_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R2: ale lasts a single cycle
  a_r2_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  // R3, R4: ale comes with both address outputs enabled
  a_r3_ale_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (ad_oe && addr_hi_oe));

  // R10: ale only in transfer cycles (status s1 xor s0)
  a_r10_ale_status: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (stat_s1 != stat_s0));

  // R8: read strobe means shared pins released
  a_r8_read_release: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  // R7: write strobe means shared pins driven
  a_r7_write_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);

  // R4: high address present under any strobe
  a_r4_hi_under_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> addr_hi_oe);

  // R5: status steady while a strobe stays active
  a_r5_status_steady: assert property (@(posedge clk) disable iff (!rst_n)
    ((!rd_n && $past(!rd_n)) || (!wr_n && $past(!wr_n)))
      |-> $stable({stat_io, stat_s1, stat_s0}));

  // R9: strobe release coincides with done
  a_r9_done_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_n) || $rose(wr_n)) |-> rsp_done);

  // R11: not ready during T1
  a_r11_busy_in_t1: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> !req_ready);
endmodule

bind mux_bus_seq mbs_checker u_chk (.*);

// File: tb/mux_bus_seq_bench.sv
module mux_bus_seq_bench;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic        req_io;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready;
  logic [7:0]  rsp_rdata;
  logic        rsp_done;
  logic        ale;
  logic [7:0]  ad_out;
  logic        ad_oe;
  logic [7:0]  ad_in;
  logic [7:0]  addr_hi;
  logic        addr_hi_oe;
  logic        stat_io, stat_s1, stat_s0;
  logic        rd_n, wr_n;

  int checks = 0;
  int fails  = 0;
  logic [7:0] last_rd = 8'h00;

  mux_bus_seq u_mux_bus_seq (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {io, kind[1:0], addr[15:0], wdata[7:0], device read byte[7:0]}
  localparam int NV = 6;
  localparam logic [34:0] VEC [NV] = '{
    {1'b0, 2'b01, 16'h12A5, 8'h00, 8'h3C},
    {1'b0, 2'b10, 16'h8001, 8'hE7, 8'h00},
    {1'b1, 2'b01, 16'h0040, 8'h00, 8'h99},
    {1'b1, 2'b10, 16'hFF7E, 8'h5A, 8'h00},
    {1'b0, 2'b00, 16'h1234, 8'h77, 8'h11},
    {1'b1, 2'b11, 16'hABCD, 8'h66, 8'h22}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_stat(input logic io, input logic [1:0] k);
    if (k == 2'b01) return {io, 2'b10};
    if (k == 2'b10) return {io, 2'b01};
    return 3'b000;
  endfunction

  task automatic drive_req(input logic [34:0] v);
    req_valid = 1'b1;
    req_io    = v[34];
    req_kind  = v[33:32];
    req_addr  = v[31:16];
    req_wdata = v[15:8];
  endtask

  task automatic check_rest(input string tag);
    check({tag, " R1 rest ale"}, ale, 1'b0);
    check({tag, " R6 rest strobes"}, {rd_n, wr_n}, 2'b11);
    check({tag, " R8 rest oe"}, {ad_oe, addr_hi_oe}, 2'b00);
    check({tag, " R5 rest status"}, {stat_io, stat_s1, stat_s0}, 3'b000);
  endtask

  // entry: just after a posedge, sequencer idle or finishing T3
  // nxt_on: queue nxt during T3 (back-to-back)
  task automatic run_cycle(input logic [34:0] v, input bit nxt_on, input logic [34:0] nxt);
    logic rd, wr, live;
    logic [2:0] st;
    rd = (v[33:32] == 2'b01);
    wr = (v[33:32] == 2'b10);
    live = rd || wr;
    st = exp_stat(v[34], v[33:32]);
    drive_req(v);
    @(posedge clk); #1 req_valid = 1'b0;
    @(negedge clk); // T1
    check("R2 ale in T1", ale, live);
    check("R3 oe in T1", ad_oe, live);
    check("R3 low addr in T1", live ? ad_out : 8'h00, live ? v[23:16] : 8'h00);
    check("R4 hi in T1", {addr_hi_oe, addr_hi}, live ? {1'b1, v[31:24]} : 9'h000);
    check("R5 status T1", {stat_io, stat_s1, stat_s0}, st);
    check("R6 no strobe T1", {rd_n, wr_n}, 2'b11);
    check("R11 busy T1", req_ready, 1'b0);
    ad_in = v[7:0]; // device data late in T2 region
    @(negedge clk); // T2
    check("R2 ale low T2", ale, 1'b0);
    check("R6 strobes T2", {rd_n, wr_n}, {!rd, !wr});
    check("R7 R8 oe T2", ad_oe, wr);
    if (wr) check("R7 wdata T2", ad_out, v[15:8]);
    check("R4 hi in T2", {addr_hi_oe, addr_hi}, live ? {1'b1, v[31:24]} : 9'h000);
    check("R5 status T2", {stat_io, stat_s1, stat_s0}, st);
    check("R11 busy T2", req_ready, 1'b0);
    if (nxt_on) drive_req(nxt);
    @(negedge clk); // T3
    check("R6 strobes T3", {rd_n, wr_n}, {!rd, !wr});
    check("R7 R8 oe T3", ad_oe, wr);
    if (wr) check("R7 wdata T3", ad_out, v[15:8]);
    check("R4 hi in T3", {addr_hi_oe, addr_hi}, live ? {1'b1, v[31:24]} : 9'h000);
    check("R5 status T3", {stat_io, stat_s1, stat_s0}, st);
    check("R11 ready T3", req_ready, 1'b1);
    check("R9 no done T3", rsp_done, 1'b0);
    @(posedge clk); #1 req_valid = 1'b0;
    if (rd) last_rd = v[7:0];
    ad_in = 8'hFF;
    @(negedge clk); // cycle after T3
    check("R9 done", rsp_done, 1'b1);
    check("R9 rdata", rsp_rdata, last_rd);
    if (!nxt_on) begin
      check_rest("after");
      check("R11 ready idle", req_ready, 1'b1);
      @(posedge clk); #1;
      check("R9 done one cycle", rsp_done, 1'b0);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : stim
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'b00; req_io = 1'b0;
    req_addr = 16'h0; req_wdata = 8'h0; ad_in = 8'hFF;
    repeat (3) @(posedge clk);
    #1;
    check_rest("R1 in reset");
    check("R1 done in reset", rsp_done, 1'b0);
    check("R1 ready in reset", req_ready, 1'b1);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check_rest("R1 after reset");

    // table of cycles: reads, writes, both spaces, bus-idle kinds
    for (int i = 0; i < NV; i++) run_cycle(VEC[i], 1'b0, 35'h0);

    // R11 back-to-back: write queued during read's T3
    run_cycle({1'b0, 2'b01, 16'h4321, 8'h00, 8'hA5}, 1'b1,
              {1'b0, 2'b10, 16'h5A69, 8'hC3, 8'h00});
    check("R11 b2b next T1 ale", ale, 1'b1);
    check("R11 b2b next T1 addr", ad_out, 8'h69);
    check("R11 b2b next status", {stat_io, stat_s1, stat_s0}, 3'b001);
    @(negedge clk);
    check("R11 b2b next T2 wdata", ad_out, 8'hC3);
    check("R11 b2b next T2 wr_n", wr_n, 1'b0);
    @(negedge clk);
    @(negedge clk);
    check("R9 b2b done", rsp_done, 1'b1);
    check("R9 write keeps rdata", rsp_rdata, 8'hA5);
    @(posedge clk); #1;

    // R11 request while busy is ignored
    drive_req({1'b0, 2'b01, 16'h1E2D, 8'h00, 8'h00});
    @(posedge clk); #1;
    drive_req({1'b1, 2'b10, 16'hC0DE, 8'h44, 8'h00}); // offered in T1
    @(negedge clk);
    check("R11 ignored T1 addr", ad_out, 8'h2D);
    @(posedge clk); #1 req_valid = 1'b0;
    @(negedge clk);
    check("R11 ignored T2 hi", addr_hi, 8'h1E);
    check("R11 ignored T2 status", {stat_io, stat_s1, stat_s0}, 3'b010);
    check("R11 ignored T2 rd_n", rd_n, 1'b0);
    ad_in = 8'h5E;
    @(posedge clk); @(posedge clk); #1;
    @(negedge clk);
    check("R9 ignored-case rdata", rsp_rdata, 8'h5E);
    @(negedge clk);
    check("R11 no ghost cycle", ale, 1'b0);
    check_rest("R11 after ignored");

    // R1 async reset in the middle of a write
    @(posedge clk); #1;
    drive_req({1'b0, 2'b10, 16'h7777, 8'h99, 8'h00});
    @(posedge clk); #1 req_valid = 1'b0;
    @(posedge clk); #1;
    check("R6 wr_n before reset", wr_n, 1'b0);
    rst_n = 1'b0;
    #1;
    check_rest("R1 mid-cycle reset");
    check("R1 rdata reset", rsp_rdata, 8'h00);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_rest("R1 after mid reset");
    check("R1 no done after reset", rsp_done, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule